// File: doc/BRIEF.md
# Per-Bunch Feedback Kick Generator

This block turns a stream of per-bunch error samples (phase or transverse position) into per-bunch kick values for a damper's output converter path. Each sample carries a bunch number. That number selects an entry in a small control memory. The entry sets how the bunch is treated: its feedback gain, whether the loop damps or anti-damps it, whether pseudo-random noise is added, whether it receives a pinger excitation, and whether it is driven out of the machine at full amplitude.

A host loads the control memory through an address/data/write-enable port. A 16-bit linear-feedback shift register supplies the noise, scaled by a global amplitude input. A turn-counted pinger adds a triangle-wave excitation. The pinger's phase steps by a tune word once per turn, and it runs only inside a window set by a start turn and a duration. Every result is clamped to the converter width.

Top module: `bunch_kick_ctrl`

## Requirements
- R1: A sample accepted with `in_valid` high appears on the output two clock edges later, with `out_valid` high and `out_bunch` equal to its bunch number. With no sample, `out_valid` is low.
- R2: The control word holds the gain in bits [7:0] (unsigned), the anti-damp flag in bit 8, noise enable in bit 9, pinger enable in bit 10 and blow-out enable in bit 11. The feedback term is the floor of (error × gain) / 16. It is negated when bit 8 is 0 (damp) and kept as it is when bit 8 is 1 (anti-damp).
- R3: Each kick uses only the control entry of its own bunch and that sample's own error value.
- R4: A host write stores `host_wdata` at `host_addr`. A sample of the same bunch accepted in the same cycle still uses the previous entry, and the next sample uses the new entry.
- R5: The kick sum is clamped to the range -2048 to +2047 (12-bit converter) and never wraps.
- R6: Noise comes from the register sequence seeded with 0xACE1, with next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. It steps once for every accepted sample. A sample with bit 9 set adds floor(signed(s) × `noise_amp` / 256), where s is the value before that step.
- R7: A turn counter starts at 0 at reset and counts `turn_mark` pulses. The pinger is active while start ≤ count < start + duration. Its 16-bit phase begins at 0 and adds `ping_tune` on each turn mark that arrives while the pinger is active.
- R8: An active pinger adds floor(w / 16) to kicks of bunches with bit 10 set. Here w = t - 16384, and t is phase[14:0] when phase[15] is 0, or its bitwise inverse when phase[15] is 1. An inactive pinger adds 0.
- R9: A bunch with bit 11 set outputs +2047 when the turn count is even and -2048 when it is odd, whatever its other terms.
- R10: After reset, `out_valid` is 0 and `out_kick` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Error sample present |
| in_bunch | input | 3 | Bunch number of the sample |
| in_err | input | 12 | Signed error value |
| turn_mark | input | 1 | One-cycle pulse per machine turn |
| host_we | input | 1 | Control memory write strobe |
| host_addr | input | 3 | Control memory write address |
| host_wdata | input | 12 | Control word |
| noise_amp | input | 8 | Global noise amplitude |
| ping_tune | input | 16 | Pinger phase step per turn |
| ping_start | input | 16 | First pinger turn |
| ping_dur | input | 16 | Pinger length in turns |
| out_valid | output | 1 | Kick present |
| out_bunch | output | 3 | Bunch number of the kick |
| out_kick | output | 12 | Signed, clamped kick value |

## Verification
A stale or corrupted control entry shows as a wrong kick for that bunch two edges after its next sample, so each bunch is read back under distinct gains and signs. A mis-stepped noise register shows up at the first noise-enabled bunch after the fault. It stays wrong from then on, because the bench runs its own copy of the sequence. A turn-counter or phase error moves the pinger window or the blow-out polarity, and this shows at the first sample after the next turn mark.

// File: rtl/kick_pkg.sv
package kick_pkg;
    localparam int GAIN_W = 8;

    typedef struct packed {
        logic              blow;
        logic              ping;
        logic              noise;
        logic              anti;
        logic [GAIN_W-1:0] gain;
    } kick_cfg_t;

    localparam int CFG_W = $bits(kick_cfg_t);
endpackage

// File: rtl/kick_cfg_ram.sv
module kick_cfg_ram #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [WIDTH-1:0] rdata_q;

    // Registered read; non-blocking write gives old data on same-address collision.
    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata_q <= mem_q[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/kick_lfsr.sv
module kick_lfsr #(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output logic [15:0] value
);
    logic [15:0] state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (step) state_d = {state_q[14:0], state_q[15] ^ state_q[13] ^ state_q[12] ^ state_q[10]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    assign value = state_q;

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 16'h0000);                                   // R6
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(state_q));                            // R6
endmodule

// File: rtl/kick_pinger.sv
module kick_pinger #(
    parameter int PH_W   = 16,
    parameter int TURN_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   turn_mark,
    input  logic [PH_W-1:0]        tune,
    input  logic [TURN_W-1:0]      start,
    input  logic [TURN_W-1:0]      dur,
    output logic [TURN_W-1:0]      turn_cnt,
    output logic                   active,
    output logic signed [PH_W-1:0] wave
);
    localparam logic [TURN_W-1:0] TURN_MAX = '1;

    typedef struct packed {
        logic [TURN_W-1:0] turn;
        logic [PH_W-1:0]   phase;
    } ping_st_t;

    ping_st_t st_d, st_q;
    logic [PH_W-2:0] tri_w;

    always_comb begin
        active = (st_q.turn >= start) && ((st_q.turn - start) < dur);
        st_d   = st_q;
        if (turn_mark) begin
            if (st_q.turn != TURN_MAX) st_d.turn = st_q.turn + 1'b1;
            if (active)                st_d.phase = st_q.phase + tune;
        end
        tri_w = st_q.phase[PH_W-1] ? ~st_q.phase[PH_W-2:0] : st_q.phase[PH_W-2:0];
        wave  = $signed({1'b0, tri_w}) - $signed({2'b01, {(PH_W-2){1'b0}}});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign turn_cnt = st_q.turn;

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !turn_mark |=> $stable(st_q.phase));                    // R7
    AST_TURN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (turn_mark && st_q.turn != TURN_MAX) |=> st_q.turn == $past(st_q.turn) + 1'b1); // R7
endmodule

// File: rtl/bunch_kick_ctrl.sv
module bunch_kick_ctrl
    import kick_pkg::*;
#(
    parameter int NBUNCH      = 8,
    parameter int ERR_W       = 12,
    parameter int DAC_W       = 12,
    parameter int AMP_W       = 8,
    parameter int PH_W        = 16,
    parameter int TURN_W      = 16,
    parameter int FB_SHIFT    = 4,
    parameter int NOISE_SHIFT = 8,
    parameter int PING_SHIFT  = 4,
    localparam int AW         = $clog2(NBUNCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [AW-1:0]           in_bunch,
    input  logic signed [ERR_W-1:0] in_err,
    input  logic                    turn_mark,
    input  logic                    host_we,
    input  logic [AW-1:0]           host_addr,
    input  logic [CFG_W-1:0]        host_wdata,
    input  logic [AMP_W-1:0]        noise_amp,
    input  logic [PH_W-1:0]         ping_tune,
    input  logic [TURN_W-1:0]       ping_start,
    input  logic [TURN_W-1:0]       ping_dur,
    output logic                    out_valid,
    output logic [AW-1:0]           out_bunch,
    output logic signed [DAC_W-1:0] out_kick
);
    localparam int SUM_W = 32;
    localparam logic signed [SUM_W-1:0] KMAX = SUM_W'((64'sd1 <<< (DAC_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] KMIN = -KMAX - 1;

    typedef struct packed {
        logic                    vld;
        logic [AW-1:0]           bunch;
        logic signed [ERR_W-1:0] err;
        logic [15:0]             noise;
        logic signed [PH_W-1:0]  wave;
        logic                    ping_on;
        logic                    odd_turn;
    } stage_t;

    typedef struct packed {
        logic                    vld;
        logic [AW-1:0]           bunch;
        logic signed [DAC_W-1:0] kick;
    } out_t;

    stage_t s1_d, s1_q;
    out_t   o_d, o_q;

    logic [CFG_W-1:0]         cfg_raw;
    kick_cfg_t                cfg;
    logic [15:0]              lfsr_val;
    logic [TURN_W-1:0]        turn_cnt;
    logic                     ping_active;
    logic signed [PH_W-1:0]   ping_wave;
    logic signed [SUM_W-1:0]  fb_t, noise_t, ping_t, sum_t;

    kick_cfg_ram #(.DEPTH(NBUNCH), .WIDTH(CFG_W)) u_ram (
        .clk  (clk),
        .we   (host_we),
        .waddr(host_addr),
        .wdata(host_wdata),
        .raddr(in_bunch),
        .rdata(cfg_raw)
    );

    kick_lfsr u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .step (in_valid),
        .value(lfsr_val)
    );

    kick_pinger #(.PH_W(PH_W), .TURN_W(TURN_W)) u_ping (
        .clk      (clk),
        .rst_n    (rst_n),
        .turn_mark(turn_mark),
        .tune     (ping_tune),
        .start    (ping_start),
        .dur      (ping_dur),
        .turn_cnt (turn_cnt),
        .active   (ping_active),
        .wave     (ping_wave)
    );

    assign cfg = kick_cfg_t'(cfg_raw);

    always_comb begin
        // stage 1: capture sample alongside the memory read
        s1_d.vld      = in_valid;
        s1_d.bunch    = in_bunch;
        s1_d.err      = in_err;
        s1_d.noise    = lfsr_val;
        s1_d.wave     = ping_wave;
        s1_d.ping_on  = ping_active;
        s1_d.odd_turn = turn_cnt[0];

        // stage 2: per-bunch arithmetic
        fb_t    = (SUM_W'(s1_q.err) * $signed(SUM_W'({1'b0, cfg.gain}))) >>> FB_SHIFT;
        if (!cfg.anti) fb_t = -fb_t;
        noise_t = '0;
        if (cfg.noise)
            noise_t = (SUM_W'($signed(s1_q.noise)) * $signed(SUM_W'({1'b0, noise_amp}))) >>> NOISE_SHIFT;
        ping_t  = '0;
        if (cfg.ping && s1_q.ping_on)
            ping_t = SUM_W'(s1_q.wave) >>> PING_SHIFT;
        sum_t   = fb_t + noise_t + ping_t;
        if (sum_t > KMAX)      sum_t = KMAX;
        else if (sum_t < KMIN) sum_t = KMIN;
        if (cfg.blow)          sum_t = s1_q.odd_turn ? KMIN : KMAX;

        o_d.vld   = s1_q.vld;
        o_d.bunch = s1_q.bunch;
        o_d.kick  = s1_q.vld ? sum_t[DAC_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            o_q  <= '0;
        end else begin
            s1_q <= s1_d;
            o_q  <= o_d;
        end
    end

    assign out_valid = o_q.vld;
    assign out_bunch = o_q.bunch;
    assign out_kick  = o_q.kick;

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid, 2));                       // R1
    AST_OUT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_bunch == $past(in_bunch, 2));         // R1
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_kick == '0);                         // R10
endmodule

// File: tb/bunch_kick_ctrl_test.sv
module bunch_kick_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [2:0] in_bunch = '0;
    logic signed [11:0] in_err = '0;
    logic turn_mark = 1'b0;
    logic host_we = 1'b0;
    logic [2:0] host_addr = '0;
    logic [11:0] host_wdata = '0;
    logic [7:0] noise_amp = 8'd16;
    logic [15:0] ping_tune = 16'h2000;
    logic [15:0] ping_start = 16'd3;
    logic [15:0] ping_dur = 16'd2;
    logic out_valid;
    logic [2:0] out_bunch;
    logic signed [11:0] out_kick;

    int checks = 0;
    int fails = 0;
    logic [15:0] tb_lfsr = 16'hACE1;

    always #4 clk = ~clk;

    bunch_kick_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bunch(in_bunch),
        .in_err(in_err), .turn_mark(turn_mark), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .noise_amp(noise_amp),
        .ping_tune(ping_tune), .ping_start(ping_start), .ping_dur(ping_dur),
        .out_valid(out_valid), .out_bunch(out_bunch), .out_kick(out_kick)
    );

    localparam int NV = 8;
    localparam int TB_B [NV] = '{0, 0, 1, 1, 2, 2, 3, 3};
    localparam int TB_E [NV] = '{100, -37, 300, -1500, 2047, -2048, 7, -7};
    localparam int TB_X [NV] = '{-100, 37, 600, -2048, -2048, 2047, -3, 4};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic host_write(input int addr, input logic [11:0] w);
        @(negedge clk);
        host_we = 1'b1; host_addr = 3'(addr); host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic pulse_turn();
        @(negedge clk);
        turn_mark = 1'b1;
        @(negedge clk);
        turn_mark = 1'b0;
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    // Sends one sample; returns kick seen two edges later and checks valid/tag.
    task automatic send(input string req, input int b, input int e, output int kick);
        @(negedge clk);
        in_valid = 1'b1; in_bunch = 3'(b); in_err = 12'(e);
        @(negedge clk);
        in_valid = 1'b0;
        tb_lfsr = lfsr_next(tb_lfsr);
        check("R1 valid", int'(out_valid), 0);
        @(negedge clk);
        check("R1 valid", int'(out_valid), 1);
        check("R1 bunch", int'(out_bunch), b);
        kick = int'(out_kick);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        tb_lfsr = 16'hACE1;
    endtask

    initial begin
        int k;
        int exp_n;
        do_reset();
        check("R10 valid", int'(out_valid), 0);
        check("R10 kick", int'(out_kick), 0);

        // bit8 anti, bit9 noise, bit10 ping, bit11 blow, [7:0] gain
        host_write(0, 12'h010);
        host_write(1, 12'h120);
        host_write(2, 12'h0FF);
        host_write(3, 12'h008);
        host_write(4, 12'h200);
        host_write(5, 12'h400);
        host_write(6, 12'h810);
        host_write(7, 12'h000);

        // R2 R3 R5 vector table
        for (int i = 0; i < NV; i++) begin
            send("R2", TB_B[i], TB_E[i], k);
            check(i >= 3 && i <= 5 ? "R5 clamp" : "R2 R3 kick", k, TB_X[i]);
        end

        // R4 collision: write bunch0 gain 64 while reading bunch0
        @(negedge clk);
        host_we = 1'b1; host_addr = 3'd0; host_wdata = 12'h040;
        in_valid = 1'b1; in_bunch = 3'd0; in_err = 12'sd10;
        @(negedge clk);
        host_we = 1'b0; in_valid = 1'b0;
        tb_lfsr = lfsr_next(tb_lfsr);
        @(negedge clk);
        check("R4 old entry", int'(out_kick), -10);
        send("R4", 0, 10, k);
        check("R4 new entry", k, -40);
        send("R3", 7, 500, k);
        check("R3 zero gain", k, 0);

        // R6 noise, twice to show per-sample stepping
        for (int n = 0; n < 2; n++) begin
            exp_n = (int'($signed(tb_lfsr)) * 16) >>> 8;
            send("R6", 4, 1000, k);
            check("R6 noise", k, exp_n);
        end

        // R7 R8 R9 pinger and blow-out
        do_reset();
        host_write(5, 12'h400);
        host_write(6, 12'h810);
        send("R7", 5, 0, k);
        check("R7 before window", k, 0);
        send("R9", 6, 0, k);
        check("R9 even turn", k, 2047);
        pulse_turn();
        send("R9", 6, 0, k);
        check("R9 odd turn", k, -2048);
        pulse_turn();
        pulse_turn();
        send("R8", 5, 0, k);
        check("R8 phase 0", k, -1024);
        pulse_turn();
        send("R8", 5, 0, k);
        check("R8 phase step", k, -512);
        pulse_turn();
        send("R7", 5, 0, k);
        check("R7 after window", k, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule